// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a clocked static memory of 16-bit words, each made of a low byte and a high byte. Its depth is set by an address-width parameter. On every rising clock edge it registers the address, the write data and all control pins. It then reads the addressed word straight out of the array, with no output register. A read therefore shows its data in the clock cycle that follows the edge at which the address was taken.

Either of two active-low address strobes starts an access: a processor strobe or a controller strobe. The strobe loads a base address and clears an internal 2-bit beat counter. After that, the advance pin steps the counter. The two low address bits follow the counter in one of two orders. Linear order adds the count to the start value, modulo 4. Interleaved order XORs the count with the start value. A mode pin, captured with the strobe, selects the order.

Writes are selected per byte, or for the whole word through a global write pin. A write is registered at one edge and lands in the array at the next edge, with no write strobe needed. Three chip enables, with mixed polarity, must all be active for the part to be selected.

Top module: `sync_burst_sram`

## Requirements
- R1: Suppose either strobe is low and all three enables are active (ce1_ni low, ce2_i high, ce3_ni low) at an edge. Then that edge loads addr_i as the current address. In the cycle after that edge, rdata_o shows the stored word and rdata_oe_o is high.
- R2: With no strobe and the part selected, advance_ni low at an edge raises the beat counter by one, modulo 4. The upper address bits never change during a burst. With advance_ni high, the current address holds.
- R3: If mode_i is low at the strobe edge, the two low address bits are (start + count) mod 4. For example, a start of 1 gives 1,2,3,0.
- R4: If mode_i is high at the strobe edge, the two low address bits are start XOR count. For example, a start of 1 gives 1,0,3,2.
- R5: A strobe arriving in the middle of a burst reloads the base address and clears the counter. It takes priority over advance_ni in the same cycle.
- R6: With global_wr_ni high and byte_wr_en_ni low, byte_wr_ni[0] low writes the low byte (bits 7:0) and byte_wr_ni[1] low writes the high byte (bits 15:8). With byte_wr_en_ni high, no byte is written.
- R7: global_wr_ni low writes both bytes, whatever byte_wr_en_ni and byte_wr_ni are.
- R8: Write controls registered at one edge write to the address current after that edge, and the array is updated at the following edge. rdata_oe_o is low in the cycle between these two edges, and the new word can be read right after the second edge.
- R9: At an edge where the processor strobe is low, the write controls are ignored. That access is a read.
- R10: A strobe with any enable inactive deselects the part. While deselected, rdata_oe_o is low, writes have no effect and advance_ni does nothing.
- R11: While rst_ni is low, the part is deselected and rdata_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, taken on a strobe |
| wdata_i | input | 16 | Write data |
| strobe_proc_ni | input | 1 | Processor address strobe, active low, always a read |
| strobe_ctl_ni | input | 1 | Controller address strobe, active low |
| advance_ni | input | 1 | Step the beat counter, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| global_wr_ni | input | 1 | Write whole word, active low |
| byte_wr_en_ni | input | 1 | Enable per-byte writes, active low |
| byte_wr_ni | input | 2 | Per-byte write selects, active low, bit 0 is the low byte |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| rdata_o | output | 16 | Flow-through read data |
| rdata_oe_o | output | 1 | Read data valid, output enable |

## Verification
A write commits to the array at the edge after it was registered. That same edge can also take a new address strobe. The commit must then go to the old address, while the new address is read from at once. The bench provokes this by registering a full-word write and then, in the very next cycle, strobing a read to a neighbouring address. It checks that the neighbour's contents come out unchanged with rdata_oe_o high. A later read of the first address must return the newly written word. A second case registers a burst write while the advance pin moves the address, and checks that each beat lands on its own word.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned WORD_W = BYTE_W * LANES;
    localparam int unsigned BEAT_W = 2;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef logic [LANES-1:0] lane_mask_t;

endpackage

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  order_e            order_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [BEAT_W-1:0] low_lin;
    logic [BEAT_W-1:0] low_ilv;

    // Only the beat field wraps; upper bits pass untouched.
    assign low_lin = base_i[BEAT_W-1:0] + beat_i;
    assign low_ilv = base_i[BEAT_W-1:0] ^ beat_i;

    always_comb begin
        addr_o = base_i;
        addr_o[BEAT_W-1:0] = (order_i == ORDER_INTERLEAVED) ? low_ilv : low_lin;
    end

endmodule

// File: rtl/sbs_write_decode.sv
module sbs_write_decode
    import sbs_pkg::*;
(
    input  logic       global_wr_ni,
    input  logic       byte_wr_en_ni,
    input  lane_mask_t byte_wr_ni,
    output lane_mask_t mask_o
);

    always_comb begin
        if (!global_wr_ni) begin
            mask_o = '1;
        end else if (!byte_wr_en_ni) begin
            mask_o = ~byte_wr_ni;
        end else begin
            mask_o = '0;
        end
    end

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  lane_mask_t        we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] store [DEPTH];

        always_ff @(posedge clk_i) begin
            if (we_i[l]) begin
                store[addr_i] <= wdata_i[l*BYTE_W +: BYTE_W];
            end
        end

        // Flow-through: no output register on the read path.
        assign rdata_o[l*BYTE_W +: BYTE_W] = store[addr_i];
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    input  logic              strobe_proc_ni,
    input  logic              strobe_ctl_ni,
    input  logic              advance_ni,
    input  logic              mode_i,
    input  logic              global_wr_ni,
    input  logic              byte_wr_en_ni,
    input  logic [1:0]        byte_wr_ni,
    input  logic              ce1_ni,
    input  logic              ce2_i,
    input  logic              ce3_ni,
    output logic [15:0]       rdata_o,
    output logic              rdata_oe_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic              sel;
        order_e            order;
        lane_mask_t        wmask;
        logic [WORD_W-1:0] wdata;
    } state_t;

    state_t state_d, state_q;

    logic              ce_all;
    logic              strobe_any;
    logic              proc_strobe;
    lane_mask_t        req_mask;
    logic [ADDR_W-1:0] cur_addr;

    assign ce_all      = !ce1_ni && ce2_i && !ce3_ni;
    assign proc_strobe = !strobe_proc_ni;
    assign strobe_any  = proc_strobe || !strobe_ctl_ni;

    sbs_write_decode u_wdec (
        .global_wr_ni  (global_wr_ni),
        .byte_wr_en_ni (byte_wr_en_ni),
        .byte_wr_ni    (byte_wr_ni),
        .mask_o        (req_mask)
    );

    sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .base_i  (state_q.base),
        .beat_i  (state_q.beat),
        .order_i (state_q.order),
        .addr_o  (cur_addr)
    );

    // A pending write lands at the address it was registered against.
    sbs_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk_i   (clk_i),
        .we_i    (state_q.wmask),
        .addr_i  (cur_addr),
        .wdata_i (state_q.wdata),
        .rdata_o (rdata_o)
    );

    always_comb begin
        state_d       = state_q;
        state_d.wmask = '0;
        state_d.wdata = wdata_i;
        if (strobe_any) begin
            if (ce_all) begin
                state_d.base  = addr_i;
                state_d.beat  = '0;
                state_d.sel   = 1'b1;
                state_d.order = order_e'(mode_i);
            end else begin
                state_d.sel = 1'b0;
            end
        end else if (!advance_ni && state_q.sel) begin
            state_d.beat = state_q.beat + 1'b1;
        end
        if (state_d.sel && !proc_strobe) begin
            state_d.wmask = req_mask;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_oe_o = state_q.sel && (state_q.wmask == '0);

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              strobe_proc_ni,
    input logic              strobe_ctl_ni,
    input logic              advance_ni,
    input logic              ce1_ni,
    input logic              ce2_i,
    input logic              ce3_ni,
    input logic              rdata_oe_o,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [1:0]        beat,
    input logic              sel
);

    logic enabled;
    logic strobed;
    assign enabled = !ce1_ni && ce2_i && !ce3_ni;
    assign strobed = !strobe_proc_ni || !strobe_ctl_ni;

    assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobed && enabled |=> cur_addr == $past(addr_i));

    assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobed && enabled |=> beat == 2'd0);

    assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobed && !advance_ni && sel |=> beat == $past(beat) + 2'd1);

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobed && advance_ni |=> $stable(cur_addr));

    assert_deselect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobed && !enabled |=> !rdata_oe_o);

    assert_proc_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_proc_ni && enabled |=> rdata_oe_o);

    always_comb begin
        if (!rst_ni) begin
            assert_reset_R11: assert (!rdata_oe_o);
        end
    end

endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (addr_i),
    .strobe_proc_ni (strobe_proc_ni),
    .strobe_ctl_ni  (strobe_ctl_ni),
    .advance_ni     (advance_ni),
    .ce1_ni         (ce1_ni),
    .ce2_i          (ce2_i),
    .ce3_ni         (ce3_ni),
    .rdata_oe_o     (rdata_oe_o),
    .cur_addr       (cur_addr),
    .beat           (state_q.beat),
    .sel            (state_q.sel)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb_top;

    localparam int unsigned AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic [15:0]   wdata;
    logic          sp_n, sc_n, adv_n, mode, gw_n, bwe_n;
    logic [1:0]    bw_n;
    logic          ce1_n, ce2, ce3_n;
    logic [15:0]   rdata;
    logic          oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] model [0:31];

    always #5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .strobe_proc_ni(sp_n), .strobe_ctl_ni(sc_n), .advance_ni(adv_n),
        .mode_i(mode), .global_wr_ni(gw_n), .byte_wr_en_ni(bwe_n),
        .byte_wr_ni(bw_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
        .rdata_o(rdata), .rdata_oe_o(oe)
    );

    task automatic idle();
        sp_n = 1; sc_n = 1; adv_n = 1; mode = 0; gw_n = 1; bwe_n = 1;
        bw_n = 2'b11; ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_read(input string req, input logic [15:0] exp);
        chk(oe === 1'b1, {req, " oe"}, {15'd0, oe}, 16'd1);
        chk(rdata === exp, req, rdata, exp);
    endtask

    // Strobe a read at a, then return inputs to idle.
    task automatic start(input logic [AW-1:0] a, input logic m, input bit use_proc);
        addr = a; mode = m;
        if (use_proc) sp_n = 0; else sc_n = 0;
        tick();
        idle();
    endtask

    task automatic step();
        adv_n = 0; tick(); adv_n = 1;
    endtask

    task automatic t_reset();
        idle();
        repeat (2) tick();
        chk(oe === 1'b0, "R11 oe in reset", {15'd0, oe}, 16'd0);
        rst_n = 1;
        tick();
        chk(oe === 1'b0, "R11 oe after reset", {15'd0, oe}, 16'd0);
    endtask

    task automatic wr_full(input logic [AW-1:0] a, input logic [15:0] d);
        sc_n = 0; addr = a; gw_n = 0; wdata = d;
        tick();
        idle();
        chk(oe === 1'b0, "R8 oe low while write pending", {15'd0, oe}, 16'd0);
        tick();
        model[a] = d;
        chk_read("R8 read back", d);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) wr_full(AW'(i), 16'h1000 + 16'(i * 17));
        start(AW'(2), 0, 0);
        chk_read("R1 single read", model[2]);
    endtask

    task automatic t_linear();
        start(AW'(5), 0, 0);
        chk_read("R3 beat0", model[5]);
        step(); chk_read("R3 beat1", model[6]);
        step(); chk_read("R3 beat2", model[7]);
        step(); chk_read("R3 beat3 wrap", model[4]);
        step(); chk_read("R2 counter wraps", model[5]);
        tick(); chk_read("R2 hold", model[5]);
    endtask

    task automatic t_interleave();
        start(AW'(6), 1, 0);
        chk_read("R4 beat0", model[6]);
        step(); chk_read("R4 beat1", model[7]);
        step(); chk_read("R4 beat2", model[4]);
        step(); chk_read("R4 beat3", model[5]);
        start(AW'(9), 1, 1);
        step(); chk_read("R4 9^1", model[8]);
        step(); chk_read("R4 9^2", model[11]);
        step(); chk_read("R4 9^3", model[10]);
    endtask

    task automatic t_bytes();
        sc_n = 0; addr = 3; bwe_n = 0; bw_n = 2'b10; wdata = 16'hAAAA;
        tick(); idle(); tick();
        model[3][7:0] = 8'hAA;
        chk_read("R6 low byte", model[3]);
        sc_n = 0; addr = 3; bwe_n = 0; bw_n = 2'b01; wdata = 16'h5555;
        tick(); idle(); tick();
        model[3][15:8] = 8'h55;
        chk_read("R6 high byte", model[3]);
        sc_n = 0; addr = 3; bwe_n = 1; bw_n = 2'b00; wdata = 16'h0000;
        tick(); idle();
        chk_read("R6 no enable no write", model[3]);
        tick(); chk_read("R6 contents kept", model[3]);
    endtask

    task automatic t_global();
        sc_n = 0; addr = 4; gw_n = 0; bwe_n = 1; bw_n = 2'b11; wdata = 16'hC3C3;
        tick(); idle(); tick();
        model[4] = 16'hC3C3;
        chk_read("R7 global over disabled bytes", model[4]);
        sc_n = 0; addr = 4; gw_n = 0; bwe_n = 0; bw_n = 2'b10; wdata = 16'h7E81;
        tick(); idle(); tick();
        model[4] = 16'h7E81;
        chk_read("R7 global over byte select", model[4]);
    endtask

    task automatic t_proc();
        sp_n = 0; addr = 7; gw_n = 0; wdata = 16'hFFFF;
        tick(); idle();
        chk_read("R9 processor strobe reads", model[7]);
        tick(); chk_read("R9 no write", model[7]);
    endtask

    task automatic t_reload();
        start(AW'(0), 0, 0);
        step(); chk_read("R5 before reload", model[1]);
        sc_n = 0; addr = 2; adv_n = 0;
        tick(); idle();
        chk_read("R5 reload beats advance", model[2]);
        step(); chk_read("R5 counter cleared", model[3]);
    endtask

    task automatic t_deselect();
        start(AW'(5), 0, 0);
        sc_n = 0; addr = 6; ce2 = 0;
        tick(); idle();
        chk(oe === 1'b0, "R10 deselect", {15'd0, oe}, 16'd0);
        step();
        chk(oe === 1'b0, "R10 advance while deselected", {15'd0, oe}, 16'd0);
        gw_n = 0; wdata = 16'h0BAD; tick(); idle(); tick();
        chk(oe === 1'b0, "R10 still deselected", {15'd0, oe}, 16'd0);
        start(AW'(5), 0, 0); chk_read("R10 no write at 5", model[5]);
        start(AW'(6), 0, 0); chk_read("R10 no write at 6", model[6]);
    endtask

    task automatic t_collide();
        sc_n = 0; addr = 10; gw_n = 0; wdata = 16'hBEEF;
        tick(); idle();
        sc_n = 0; addr = 11;
        tick(); idle();
        model[10] = 16'hBEEF;
        chk_read("R8 new strobe during commit", model[11]);
        start(AW'(10), 0, 0);
        chk_read("R8 commit went to old address", model[10]);
        sc_n = 0; addr = 12; gw_n = 0; wdata = 16'h1234;
        tick();
        sc_n = 1; adv_n = 0; wdata = 16'h5678;
        tick(); idle(); tick();
        model[12] = 16'h1234; model[13] = 16'h5678;
        start(AW'(12), 0, 0); chk_read("R2 burst write beat0", model[12]);
        step(); chk_read("R2 burst write beat1", model[13]);
    endtask

    initial begin
        addr = '0; wdata = '0;
        idle();
        t_reset();
        t_fill();
        t_linear();
        t_interleave();
        t_bytes();
        t_global();
        t_proc();
        t_reload();
        t_deselect();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule